// File: doc/BRIEF.md
# Dual-Clock Interval Countdown Timer

This block is a programmable down-counter for timeouts and periodic events. Software writes a start value, picks a prescale ratio and a count source, and then sets the run bit. The source is either the bus clock or a slow 32 kHz reference that has no fixed phase relation to the bus. When the count reaches zero, a sticky expiry flag is set. That flag drives an interrupt line and a wake-up line, and each line has its own mask.

All registers live in the bus clock domain. The run bit and load requests cross into the count domain through two-flop synchronizers. The expiry event returns to the bus domain as a toggle.

When the reference clock is selected, a single sample of the count may be caught mid-transition. A count read therefore stalls on `ready_o` until two back-to-back bus-side samples match. When the bus clock is the source, the count is already synchronous, so a count read completes at once.

Top module: `cdc_down_timer`

## Requirements
- R1: A write to the count register (address 1) loads the start value only while the run bit is 0. A write to address 1 while running is ignored and the count carries on.
- R2: Each decrement takes PRESCALE+1 cycles of the selected source. PRESCALE is control bits [15:8].
- R3: Once the count reaches zero it stays at zero until software loads a new value. It never wraps.
- R4: The expiry flag is control bit 4 and is 0 after reset. It is set on expiry. Writing 1 to bit 4 clears it. Writing 0 to bit 4 leaves it unchanged.
- R5: `irq_o` equals the flag ANDed with the interrupt mask (bit 2). `wake_o` equals the flag ANDed with the wake mask (bit 3).
- R6: Clearing the run bit (bit 0) stops the count and keeps its value.
- R7: Source select is bit 1: 0 selects the bus clock and 1 selects `ref_clk_i`. With bit 1 set, the count advances on the reference clock.
- R8: With the reference source, a count read waits at least two cycles and completes only when two consecutive samples agree. The value returned is a count that actually occurred.
- R9: With the bus clock source, a count read completes in the cycle it is issued.
- R10: Source select changes only while the run bit is 0, and switching the source leaves the count unchanged.
- R11: The counter width is a parameter. A 16-bit instance keeps the low 16 bits of a loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| ref_clk_i | input | 1 | Slow asynchronous reference clock |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = control, 1 = count |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | Access completes this cycle |
| irq_o | output | 1 | Masked expiry interrupt |
| wake_o | output | 1 | Masked expiry wake-up request |

## Verification
The hardest case to reach is a count read while the timer runs from the reference clock. That read stalls until two fresh samples agree, so its latency depends on where the reference edges fall. The bench runs a 74 ns reference against a 10 ns bus clock so the two drift relative to each other. It reads in the middle of a countdown and checks both the minimum stall and that the value lies within the loaded range. It also switches the source while stopped and confirms the count survives the change in both directions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;
  localparam int BIT_RUN    = 0;
  localparam int BIT_SEL    = 1;
  localparam int BIT_IRQ    = 2;
  localparam int BIT_WAKE   = 3;
  localparam int BIT_FLAG   = 4;
  localparam int PRE_LSB    = 8;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ld_tgl_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_tgl_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             ld_prev_q, evt_q;
  logic             ld_pulse;

  assign ld_pulse = ld_tgl_i ^ ld_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pre_q     <= '0;
      ld_prev_q <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      ld_prev_q <= ld_tgl_i;
      if (ld_pulse) begin
        cnt_q <= ld_val_i;
        pre_q <= '0;
      end else if (!run_i) begin
        pre_q <= '0;
      end else if (cnt_q != '0) begin
        if (pre_q == pre_i) begin
          pre_q <= '0;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) evt_q <= ~evt_q;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign evt_tgl_o = evt_q;

  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !ld_pulse) |=> cnt_q == '0); // R3
  AST_DOWN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_pulse |=> cnt_q <= $past(cnt_q)); // R2
  AST_FROZEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_pulse) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/tmr_snap.sv
module tmr_snap #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             async_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] data_o,
  output logic             ready_o
);
  logic [CNT_W-1:0] samp_a_q, samp_b_q;
  logic [1:0]       age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_a_q <= '0;
      samp_b_q <= '0;
      age_q    <= '0;
    end else begin
      samp_a_q <= cnt_i;
      samp_b_q <= samp_a_q;
      if (!rd_i)             age_q <= '0;
      else if (age_q != 2'd2) age_q <= age_q + 1'b1;
    end
  end

  assign ready_o = !async_i || (age_q == 2'd2 && samp_a_q == samp_b_q);
  assign data_o  = async_i ? samp_b_q : cnt_i;

  AST_ASYNC_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && async_i && age_q != 2'd2) |-> !ready_o); // R8
  AST_SYNC_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !async_i) |-> ready_o); // R9
endmodule

// File: rtl/cdc_down_timer.sv
module cdc_down_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_clk_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        ready_o,
  output logic        irq_o,
  output logic        wake_o
);
  logic             run_q, sel_q, irq_en_q, wake_en_q, flag_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] ld_val_q, cnt, snap;
  logic             ld_tgl_q, ld_tgl_s, run_s;
  logic             evt_tgl, evt_tgl_s, evt_prev_q, evt_pulse;
  logic             cnt_clk, wr_ctrl, wr_cnt, rd_cnt, snap_ready;
  logic [31:0]      ctrl_word;

  assign wr_ctrl = req_i && we_i && addr_i == ADDR_CTRL;
  assign wr_cnt  = req_i && we_i && addr_i == ADDR_CNT;
  assign rd_cnt  = req_i && !we_i && addr_i == ADDR_CNT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; sel_q <= 1'b0; irq_en_q <= 1'b0; wake_en_q <= 1'b0;
      pre_q <= '0; ld_val_q <= '0; ld_tgl_q <= 1'b0;
      flag_q <= 1'b0; evt_prev_q <= 1'b0;
    end else begin
      evt_prev_q <= evt_tgl_s;
      if (wr_ctrl) begin
        run_q     <= wdata_i[BIT_RUN];
        irq_en_q  <= wdata_i[BIT_IRQ];
        wake_en_q <= wdata_i[BIT_WAKE];
        pre_q     <= wdata_i[PRE_LSB +: PRE_W];
        if (!run_q) sel_q <= wdata_i[BIT_SEL];
      end
      if (wr_cnt && !run_q) begin
        ld_val_q <= wdata_i[CNT_W-1:0];
        ld_tgl_q <= ~ld_tgl_q;
      end
      if (evt_pulse)                        flag_q <= 1'b1;
      else if (wr_ctrl && wdata_i[BIT_FLAG]) flag_q <= 1'b0;
    end
  end

  assign evt_pulse = evt_tgl_s ^ evt_prev_q;

  // Source mux; sel_q only moves while stopped
  assign cnt_clk = sel_q ? ref_clk_i : clk_i;

  tmr_sync #(.W(2), .STAGES(2)) u_to_cnt (
    .clk_i(cnt_clk), .rst_ni(rst_ni),
    .d_i({ld_tgl_q, run_q}), .q_o({ld_tgl_s, run_s})
  );

  tmr_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_count (
    .clk_i(cnt_clk), .rst_ni(rst_ni), .run_i(run_s), .ld_tgl_i(ld_tgl_s),
    .ld_val_i(ld_val_q), .pre_i(pre_q), .cnt_o(cnt), .evt_tgl_o(evt_tgl)
  );

  tmr_sync #(.W(1), .STAGES(2)) u_to_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(evt_tgl), .q_o(evt_tgl_s)
  );

  tmr_snap #(.CNT_W(CNT_W)) u_snap (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_cnt), .async_i(sel_q),
    .cnt_i(cnt), .data_o(snap), .ready_o(snap_ready)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_RUN]  = run_q;
    ctrl_word[BIT_SEL]  = sel_q;
    ctrl_word[BIT_IRQ]  = irq_en_q;
    ctrl_word[BIT_WAKE] = wake_en_q;
    ctrl_word[BIT_FLAG] = flag_q;
    ctrl_word[PRE_LSB +: PRE_W] = pre_q;
  end

  assign rdata_o = (addr_i == ADDR_CNT) ? 32'(snap) : ctrl_word;
  assign ready_o = req_i && (!rd_cnt || snap_ready);
  assign irq_o   = flag_q && irq_en_q;
  assign wake_o  = flag_q && wake_en_q;

  AST_LOAD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt && run_q) |=> $stable(ld_tgl_q)); // R1
  AST_SEL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> $stable(sel_q)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_ctrl && wdata_i[BIT_FLAG])) |=> flag_q); // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || wake_o) |-> flag_q); // R5
endmodule

// File: tb/test_cdc_down_timer.sv
module test_cdc_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HALF   = 37;

  logic clk = 0, ref_clk = 0, rst_n = 0;
  logic req = 0, we = 0, addr = 0;
  logic [31:0] wdata = '0, rdata;
  logic ready, irq, wake;
  logic req16 = 0, we16 = 0, addr16 = 0;
  logic [31:0] wdata16 = '0, rdata16;
  logic ready16, irq16, wake16;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(REF_HALF) ref_clk = ~ref_clk;

  cdc_down_timer #(.CNT_W(32)) i_cdc_down_timer (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .irq_o(irq), .wake_o(wake));

  cdc_down_timer #(.CNT_W(16)) i_cdc_down_timer_w16 (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .req_i(req16), .we_i(we16),
    .addr_i(addr16), .wdata_i(wdata16), .rdata_o(rdata16), .ready_o(ready16),
    .irq_o(irq16), .wake_o(wake16));

  task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as reads complete
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [31:0] g, e;
      string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(t, g == e, g, e);
    end
  end

  task automatic bus_wr(input logic a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic a, output logic [31:0] d, output int waits);
    @(negedge clk); req = 1; we = 0; addr = a; waits = 0;
    #1;
    while (!ready) begin @(negedge clk); #1; waits++; end
    d = rdata;
    @(posedge clk); #1; req = 0;
  endtask

  task automatic expect_rd(input logic a, input logic [31:0] e, input string tag);
    logic [31:0] d; int w;
    bus_rd(a, d, w);
    exp_q.push_back(e); tag_q.push_back(tag); got_q.push_back(d);
  endtask

  task automatic wr16(input logic a, input logic [31:0] d);
    @(negedge clk); req16 = 1; we16 = 1; addr16 = a; wdata16 = d;
    @(posedge clk); #1; req16 = 0; we16 = 0;
  endtask

  task automatic rd16(input logic a, output logic [31:0] d);
    @(negedge clk); req16 = 1; we16 = 0; addr16 = a;
    #1; while (!ready16) begin @(negedge clk); #1; end
    d = rdata16;
    @(posedge clk); #1; req16 = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, c1, c2;
    int w;
    idle(3); rst_n = 1; idle(2);

    // reset state
    chk("R4 reset irq", irq == 0, irq, 0);
    chk("R5 reset wake", wake == 0, wake, 0);
    expect_rd(0, 32'h0, "R4 reset ctrl");
    expect_rd(1, 32'h0, "R1 reset count");

    // R1 load while stopped, R9 immediate sync read
    bus_wr(1, 32'd1234); idle(5);
    bus_rd(1, d, w);
    chk("R1 load readback", d == 1234, d, 1234);
    chk("R9 sync read waits", w == 0, w, 0);

    // R10 switch source while stopped
    bus_wr(0, 32'h2); idle(40);
    bus_rd(1, d, w);
    chk("R10 count after switch to ref", d == 1234, d, 1234);
    chk("R8 async read stalls", w >= 2, w, 2);
    bus_wr(0, 32'h0); idle(10);
    expect_rd(1, 32'd1234, "R10 count after switch back");

    // R2 prescale 4, load 10, irq mask on
    bus_wr(1, 32'd10); idle(5);
    bus_wr(0, (32'd4 << 8) | 32'h5);
    idle(40);
    chk("R2 not expired early", irq == 0, irq, 0);
    idle(30);
    chk("R5 irq on expiry", irq == 1, irq, 1);
    chk("R5 wake masked", wake == 0, wake, 0);
    expect_rd(0, (32'd4 << 8) | 32'h15, "R2 flag set");
    idle(50);
    expect_rd(1, 32'd0, "R3 holds at zero");

    // R4 write 0 keeps, R5 wake mask only
    bus_wr(0, 32'h8); idle(2);
    chk("R4 write0 keeps flag", wake == 1, wake, 1);
    chk("R5 irq masked", irq == 0, irq, 0);
    bus_wr(0, 32'h18); idle(2);
    chk("R4 write1 clears", wake == 0, wake, 0);
    expect_rd(0, 32'h8, "R4 flag clear");

    // R6 stop preserves count
    bus_wr(1, 32'd50000); idle(5);
    bus_wr(0, 32'h1); idle(100);
    bus_wr(0, 32'h0); idle(10);
    bus_rd(1, c1, w); idle(50);
    bus_rd(1, c2, w);
    chk("R6 count frozen", c1 == c2, c2, c1);
    chk("R6 count advanced", c1 < 50000 && c1 > 49000, c1, 49900);

    // R1 load ignored while running
    bus_wr(0, 32'h1);
    bus_wr(1, 32'd5); idle(20);
    bus_wr(0, 32'h0); idle(10);
    bus_rd(1, d, w);
    chk("R1 load ignored when running", d > 1000 && d < c1, d, c1);
    expect_rd(0, 32'h0, "R1 no expiry");

    // R7/R8 ref-clock countdown
    bus_wr(0, 32'h2); idle(10);
    bus_wr(1, 32'd8); idle(40);
    expect_rd(1, 32'd8, "R7 ref load");
    bus_wr(0, 32'h3); idle(35);
    bus_rd(1, d, w);
    chk("R8 mid-count value in range", d <= 8, d, 8);
    chk("R8 mid-count stall", w >= 2, w, 2);
    expect_rd(0, 32'h3, "R7 not yet expired");
    idle(150);
    expect_rd(0, 32'h13, "R7 expired on ref clock");
    expect_rd(1, 32'd0, "R3 ref count zero");

    // R11 16-bit instance
    wr16(1, 32'h12345); idle(5);
    rd16(1, d);
    chk("R11 w16 truncation", d == 32'h2345, d, 32'h2345);
    wr16(1, 32'd3); idle(3);
    wr16(0, 32'h5); idle(20);
    chk("R11 w16 expiry irq", irq16 == 1, irq16, 1);

    idle(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule